// File: doc/BRIEF.md
# DMA Submission Queue Doorbell Tracker

This block is the hardware side of a single DMA submission queue. Software places descriptors in a power-of-two ring in memory and then tells the queue how many new ones it has written. It does this by writing a count to a doorbell register. The count is added to the queue's internal tail; it is not an absolute index. A fetch-side consumer takes slot indices one at a time from the head through a valid/ready handshake. Each slot index comes with the 2-bit lap phase that the descriptor in that slot is expected to carry, so that stale entries from an earlier lap can be told apart from fresh ones.

A small register port gives software access to the queue. Through it, software can:
- enable or pause the queue with two bits, one for prefetch and one for scheduling;
- reset the queue pointers with a one-shot control bit;
- read the pending count, the error flags, the free-slot count and the pointers.

The free-slot count keeps a permanent 16-entry guard gap. A doorbell that is out of range, or one that would overfill the ring, is dropped and leaves a sticky flag.

The queue runs a four-state machine: FLUSH, IDLE, RUN and HALT.

| Transition | From | To | Condition |
|---|---|---|---|
| reset | any state | FLUSH | the software reset bit is written |
| settle | FLUSH | IDLE, RUN or HALT | one cycle after FLUSH, by enables and pending count |
| fill | IDLE | RUN | work arrives while both enables are set |
| drain | RUN | IDLE | the last pending slot is consumed |
| pause | IDLE or RUN | HALT | either enable bit is cleared |
| resume | HALT | IDLE or RUN | both enable bits are set again |

Top module: `dq_tracker`

## Requirements
- R1: After power-on reset the queue reads as follows: pending 0, head 0, tail 0, phase 1, control 0x3 with both enables set, free count DEPTH-16, both flags clear, and state IDLE one cycle after reset is released.
- R2: Writing n to offset 0x38, with 1 <= n <= DEPTH, adds n to the tail modulo DEPTH and adds n to the pending count.
- R3: A doorbell value of 0, or one above DEPTH, leaves head, tail and pending unchanged and sets the sticky reject flag, bit 16 of the status register at 0x08.
- R4: A valid doorbell that would take the pending count above DEPTH is dropped and sets the sticky overflow flag, bit 17 of 0x08. The pending count never exceeds DEPTH.
- R5: fetch_valid is high exactly when both enables are set and pending is non-zero. fetch_slot shows the head. Each accepted handshake moves the head forward by 1 modulo DEPTH and lowers pending by 1.
- R6: fetch_phase shows the 2-bit lap phase. The phase starts at 1 and increments modulo 4 each time the head wraps from DEPTH-1 to 0.
- R7: Register 0x0C reads (head - (tail + 16)) masked with DEPTH-1.
- R8: The control register at 0x00 holds bit 0 (prefetch enable) and bit 1 (scheduling enable). Slots are offered only while both bits are set. Clearing either bit pauses the queue without changing any pointer, and doorbells are still accepted while the queue is paused.
- R9: Writing 0x04 with bit 8 set sets head and tail to 0, pending to 0 and phase to 1, and clears both flags; the enable bits are kept. A write to 0x04 with bit 8 clear has no effect.
- R10: Status bits [25:24] report the state, encoded FLUSH=0, IDLE=1, RUN=2, HALT=3. A queue reset gives FLUSH for one cycle, and the queue then settles to IDLE, RUN or HALT. Register 0x10 packs the head in [11:0], the tail in [23:12] and the phase in [25:24]. The pending count sits in the low bits of 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fetch_valid | output | 1 | A slot is offered to the fetch side |
| fetch_ready | input | 1 | The fetch side accepts the offered slot |
| fetch_slot | output | IDX_W | Slot index at the head |
| fetch_phase | output | 2 | Expected lap phase for that slot |

## Verification
A register write takes effect at the clock edge where reg_wr is sampled. Pointers, pending count, flags and state all change at that same edge, because the state register is loaded from next-cycle values, so fetch_valid reflects a doorbell with no additional cycle of lag. A fetch handshake moves the head and the phase at the edge where it is accepted. The bench drives every input on a falling edge and samples the combinational read data and fetch outputs on the next falling edge, one step after the edge that should have produced the result. The one cycle of FLUSH after a queue reset is checked at that first falling edge, and the settled state is checked one cycle later.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int GUARD_SLOTS = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SWCTL = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FREE  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PTRS  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DBELL = 8'h38;

    localparam int SWCTL_RST_BIT = 8;
    localparam int STAT_REJ_BIT  = 16;
    localparam int STAT_OVF_BIT  = 17;

    typedef enum logic [1:0] {
        QS_FLUSH = 2'd0,
        QS_IDLE  = 2'd1,
        QS_RUN   = 2'd2,
        QS_HALT  = 2'd3
    } qstate_e;

endpackage

// File: rtl/dq_regfile.sv
module dq_regfile (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_bits,
    input  logic       swctl_wr,
    input  logic       swctl_rst_bit,
    input  logic       db_bad,
    input  logic       db_ovf,
    output logic [1:0] en_q,
    output logic [1:0] en_nxt,
    output logic       qrst,
    output logic       bad_flag,
    output logic       ovf_flag
);

    always_comb begin
        en_nxt = ctrl_wr ? ctrl_bits : en_q;
        qrst   = swctl_wr & swctl_rst_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 2'b11;
            bad_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            en_q <= en_nxt;
            if (qrst) begin
                bad_flag <= 1'b0;
                ovf_flag <= 1'b0;
            end else begin
                bad_flag <= bad_flag | db_bad;
                ovf_flag <= ovf_flag | db_ovf;
            end
        end
    end

endmodule

// File: rtl/dq_dbcheck.sv
module dq_dbcheck #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              db_wr,
    input  logic [DATA_W-1:0] db_val,
    input  logic [CNT_W-1:0]  pend_q,
    output logic              db_add,
    output logic [CNT_W-1:0]  db_n,
    output logic              db_bad,
    output logic              db_ovf
);

    localparam logic [DATA_W-1:0] DEPTH_D = DATA_W'(DEPTH);
    localparam logic [CNT_W:0]    DEPTH_S = (CNT_W+1)'(DEPTH);

    logic           range_ok;
    logic [CNT_W:0] sum;
    logic           fits;

    always_comb begin
        range_ok = (db_val != '0) && (db_val <= DEPTH_D);
        db_n     = db_val[CNT_W-1:0];
        sum      = {1'b0, pend_q} + {1'b0, db_n};
        fits     = (sum <= DEPTH_S);
        db_bad   = db_wr & ~range_ok;
        db_ovf   = db_wr & range_ok & ~fits;
        db_add   = db_wr & range_ok & fits;
    end

endmodule

// File: rtl/dq_ptrs.sv
module dq_ptrs #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qrst,
    input  logic             db_add,
    input  logic [CNT_W-1:0] db_n,
    input  logic             fire,
    output logic [IDX_W-1:0] head_q,
    output logic [IDX_W-1:0] tail_q,
    output logic [1:0]       phase_q,
    output logic [CNT_W-1:0] pend_q,
    output logic [CNT_W-1:0] pend_nxt,
    output logic [IDX_W-1:0] free_slots
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);
    localparam logic [IDX_W-1:0] GUARD    = IDX_W'(dq_pkg::GUARD_SLOTS);
    localparam logic [1:0]       PHASE0   = 2'd1;

    logic [IDX_W-1:0] head_nxt, tail_nxt;
    logic [1:0]       phase_nxt;
    logic [CNT_W-1:0] add_amt;

    always_comb begin
        add_amt = db_add ? db_n : '0;
        if (qrst) begin
            head_nxt  = '0;
            tail_nxt  = '0;
            phase_nxt = PHASE0;
            pend_nxt  = '0;
        end else begin
            head_nxt  = fire ? head_q + 1'b1 : head_q;
            phase_nxt = (fire && head_q == IDX_LAST) ? phase_q + 2'd1 : phase_q;
            tail_nxt  = tail_q + add_amt[IDX_W-1:0];
            pend_nxt  = pend_q + add_amt - (fire ? CNT_W'(1) : CNT_W'(0));
        end
        free_slots = head_q - (tail_q + GUARD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            phase_q <= PHASE0;
            pend_q  <= '0;
        end else begin
            head_q  <= head_nxt;
            tail_q  <= tail_nxt;
            phase_q <= phase_nxt;
            pend_q  <= pend_nxt;
        end
    end

endmodule

// File: rtl/dq_fsm.sv
module dq_fsm #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qrst,
    input  logic [1:0]       en_nxt,
    input  logic [CNT_W-1:0] pend_nxt,
    output dq_pkg::qstate_e  state_q,
    output logic             fetch_valid
);
    import dq_pkg::*;

    qstate_e state_nxt;
    logic    run_ok, has_work;

    always_comb begin
        run_ok    = (en_nxt == 2'b11);
        has_work  = (pend_nxt != '0);
        state_nxt = state_q;
        unique case (state_q)
            QS_FLUSH: state_nxt = !run_ok ? QS_HALT : (has_work ? QS_RUN : QS_IDLE);
            QS_IDLE:  if (!run_ok)       state_nxt = QS_HALT;
                      else if (has_work) state_nxt = QS_RUN;
            QS_RUN:   if (!run_ok)       state_nxt = QS_HALT;
                      else if (!has_work) state_nxt = QS_IDLE;
            QS_HALT:  if (run_ok)        state_nxt = has_work ? QS_RUN : QS_IDLE;
            default:  state_nxt = QS_FLUSH;
        endcase
        if (qrst) state_nxt = QS_FLUSH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= QS_FLUSH;
        else        state_q <= state_nxt;
    end

    always_comb begin
        fetch_valid = (state_q == QS_RUN);
    end

endmodule

// File: rtl/dq_tracker.sv
module dq_tracker #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             fetch_valid,
    input  logic             fetch_ready,
    output logic [IDX_W-1:0] fetch_slot,
    output logic [1:0]       fetch_phase
);
    import dq_pkg::*;

    generate
        if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 32 || DEPTH > 4096) begin : g_bad_depth
            $error("DEPTH must be a power of two from 32 to 4096");
        end
    endgenerate

    logic             ctrl_wr, swctl_wr, db_wr, qrst, fire;
    logic [1:0]       en_q, en_nxt;
    logic             bad_flag, ovf_flag, db_bad, db_ovf, db_add;
    logic [CNT_W-1:0] db_n, pend_q, pend_nxt;
    logic [IDX_W-1:0] head_q, tail_q, free_slots;
    logic [1:0]       phase_q;
    qstate_e          state_q;

    always_comb begin
        ctrl_wr  = reg_wr && (reg_addr == OFS_CTRL);
        swctl_wr = reg_wr && (reg_addr == OFS_SWCTL);
        db_wr    = reg_wr && (reg_addr == OFS_DBELL);
        fire     = fetch_valid && fetch_ready;
    end

    dq_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_bits(reg_wdata[1:0]),
        .swctl_wr(swctl_wr), .swctl_rst_bit(reg_wdata[SWCTL_RST_BIT]),
        .db_bad(db_bad), .db_ovf(db_ovf),
        .en_q(en_q), .en_nxt(en_nxt), .qrst(qrst),
        .bad_flag(bad_flag), .ovf_flag(ovf_flag)
    );

    dq_dbcheck #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dbchk (
        .db_wr(db_wr), .db_val(reg_wdata), .pend_q(pend_q),
        .db_add(db_add), .db_n(db_n), .db_bad(db_bad), .db_ovf(db_ovf)
    );

    dq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .qrst(qrst),
        .db_add(db_add), .db_n(db_n), .fire(fire),
        .head_q(head_q), .tail_q(tail_q), .phase_q(phase_q),
        .pend_q(pend_q), .pend_nxt(pend_nxt), .free_slots(free_slots)
    );

    dq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .qrst(qrst),
        .en_nxt(en_nxt), .pend_nxt(pend_nxt),
        .state_q(state_q), .fetch_valid(fetch_valid)
    );

    always_comb begin
        fetch_slot  = head_q;
        fetch_phase = phase_q;
        reg_rdata   = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata[1:0] = en_q;
            OFS_STAT: begin
                reg_rdata[CNT_W-1:0]   = pend_q;
                reg_rdata[STAT_REJ_BIT] = bad_flag;
                reg_rdata[STAT_OVF_BIT] = ovf_flag;
                reg_rdata[25:24]        = state_q;
            end
            OFS_FREE: reg_rdata[IDX_W-1:0] = free_slots;
            OFS_PTRS: begin
                reg_rdata[IDX_W-1:0]   = head_q;
                reg_rdata[12 +: IDX_W] = tail_q;
                reg_rdata[25:24]       = phase_q;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dq_tracker_chk.sv
module dq_tracker_chk #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             fetch_ready,
    input logic [IDX_W-1:0] head_q,
    input logic [1:0]       phase_q,
    input logic [CNT_W-1:0] pend_q,
    input logic [1:0]       en_q,
    input logic             qrst,
    input logic             db_bad,
    input logic             db_ovf,
    input logic             bad_flag,
    input logic             ovf_flag
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q <= DEPTH_C); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        db_ovf |=> ovf_flag); // R4
    AST_VALID_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> pend_q != '0); // R5
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && !qrst) |=> head_q == $past(head_q) + 1'b1); // R5
    AST_PHASE_LAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && !qrst && head_q == '1) |=> phase_q == $past(phase_q) + 2'd1); // R6
    AST_PAUSE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != 2'b11) |-> !fetch_valid); // R8
    AST_REJECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        db_bad |=> bad_flag); // R3
    AST_REJECT_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (db_bad && !(fetch_valid && fetch_ready)) |=> pend_q == $past(pend_q)); // R3
    AST_QRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        qrst |=> (pend_q == '0 && phase_q == 2'd1 && !bad_flag && !ovf_flag)); // R9

endmodule

bind dq_tracker dq_tracker_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .head_q(head_q), .phase_q(phase_q), .pend_q(pend_q), .en_q(en_q), .qrst(qrst),
    .db_bad(db_bad), .db_ovf(db_ovf), .bad_flag(bad_flag), .ovf_flag(ovf_flag)
);

// File: tb/sim_dq_tracker.sv
module sim_dq_tracker;

    localparam int DEPTH = 64;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int MASK  = DEPTH - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_addr = 8'h00;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             fetch_valid;
    logic             fetch_ready = 1'b0;
    logic [IDX_W-1:0] fetch_slot;
    logic [1:0]       fetch_phase;

    int checks = 0;
    int errors = 0;
    int exp_head = 0, exp_tail = 0, exp_pend = 0, exp_phase = 1;

    always #4 clk = ~clk;

    dq_tracker #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_ready(fetch_ready), .fetch_slot(fetch_slot), .fetch_phase(fetch_phase)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ptrs_word(input int h, input int t, input int ph);
        return 32'(h) | (32'(t) << 12) | (32'(ph) << 24);
    endfunction

    task automatic expect_regs(input string tag, input int state, input bit rej, input bit ovf);
        logic [31:0] d;
        rd(8'h08, d);
        chk({tag, " pending/flags/state"}, d,
            32'(exp_pend) | (32'(rej) << 16) | (32'(ovf) << 17) | (32'(state) << 24));
        rd(8'h10, d);
        chk({tag, " ptrs"}, d, ptrs_word(exp_head, exp_tail, exp_phase));
    endtask

    task automatic fetch_one(input string tag);
        chk({tag, " valid"}, 32'(fetch_valid), 32'd1);
        chk({tag, " slot"}, 32'(fetch_slot), 32'(exp_head));
        chk({tag, " phase"}, 32'(fetch_phase), 32'(exp_phase));
        fetch_ready = 1'b1;
        @(negedge clk);
        fetch_ready = 1'b0;
        if (exp_head == MASK) exp_phase = (exp_phase + 1) % 4;
        exp_head = (exp_head + 1) & MASK;
        exp_pend--;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        expect_regs("R1 R10 reset", 1, 0, 0);
        rd(8'h00, d); chk("R1 ctrl reset", d, 32'h3);
        rd(8'h0C, d); chk("R1 free reset", d, 32'(DEPTH - 16));
        chk("R1 no fetch at reset", 32'(fetch_valid), 32'd0);
    endtask

    task automatic t_doorbell_drain;
        wr(8'h38, 32'd5); exp_tail = 5; exp_pend = 5;
        expect_regs("R2 R10 doorbell 5", 2, 0, 0);
        wr(8'h38, 32'd3); exp_tail = 8; exp_pend = 8;
        expect_regs("R2 doorbell 3", 2, 0, 0);
        for (int i = 0; i < 8; i++) fetch_one("R5 drain");
        #1;
        expect_regs("R5 R10 drained", 1, 0, 0);
        chk("R5 no fetch when empty", 32'(fetch_valid), 32'd0);
    endtask

    task automatic t_reject;
        wr(8'h38, 32'd0);
        expect_regs("R3 zero doorbell", 1, 1, 0);
        wr(8'h38, 32'(DEPTH + 1));
        expect_regs("R3 oversize doorbell", 1, 1, 0);
    endtask

    task automatic t_overflow_free;
        logic [31:0] d;
        wr(8'h38, 32'd60); exp_tail = (exp_tail + 60) & MASK; exp_pend = 60;
        expect_regs("R2 doorbell 60", 2, 1, 0);
        rd(8'h0C, d); chk("R7 free count", d, 32'((exp_head - (exp_tail + 16)) & MASK));
        wr(8'h38, 32'd5);
        expect_regs("R4 overflow dropped", 2, 1, 1);
        wr(8'h38, 32'd4); exp_tail = (exp_tail + 4) & MASK; exp_pend = 64;
        expect_regs("R4 fill to depth", 2, 1, 1);
        rd(8'h0C, d); chk("R7 free count full", d, 32'((exp_head - (exp_tail + 16)) & MASK));
    endtask

    task automatic t_swreset;
        logic [31:0] d;
        wr(8'h04, 32'h0FF);
        expect_regs("R9 no bit8 ignored", 2, 1, 1);
        wr(8'h04, 32'h100);
        exp_head = 0; exp_tail = 0; exp_pend = 0; exp_phase = 1;
        expect_regs("R9 R10 queue reset flush", 0, 0, 0);
        rd(8'h00, d); chk("R9 enables kept", d, 32'h3);
        @(negedge clk);
        expect_regs("R10 settle idle", 1, 0, 0);
    endtask

    task automatic t_pause;
        wr(8'h38, 32'd4); exp_tail = 4; exp_pend = 4;
        wr(8'h00, 32'h1);
        expect_regs("R8 R10 pause prefetch only", 3, 0, 0);
        chk("R8 paused no fetch", 32'(fetch_valid), 32'd0);
        wr(8'h38, 32'd2); exp_tail = 6; exp_pend = 6;
        expect_regs("R8 doorbell while paused", 3, 0, 0);
        wr(8'h00, 32'h2);
        expect_regs("R8 sched only still paused", 3, 0, 0);
        chk("R8 sched only no fetch", 32'(fetch_valid), 32'd0);
        wr(8'h00, 32'h3);
        expect_regs("R8 R10 resume", 2, 0, 0);
        for (int i = 0; i < 6; i++) fetch_one("R8 R5 after resume");
    endtask

    task automatic t_phase_laps;
        for (int lap = 0; lap < 5; lap++) begin
            wr(8'h38, 32'(DEPTH)); exp_tail = (exp_tail + DEPTH) & MASK; exp_pend = DEPTH;
            for (int i = 0; i < DEPTH; i++) fetch_one("R6 lap phase");
        end
        #1;
        expect_regs("R6 after laps", 1, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        t_reset();
        t_doorbell_drain();
        t_reject();
        t_overflow_free();
        t_swreset();
        t_pause();
        t_phase_laps();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule